// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Output Driver

This block is the digital core of a serially loaded parallel output driver. A serial bit stream, timed by the serial clock, fills a shift register. A hold stage copies the register contents to a set of parallel channel outputs under control of a load input. A blank input turns every output off without touching the held word. The last register stage drives a serial output, so several drivers can be wired end to end and loaded from a single data line.

A word is sent most significant bit first. With N drivers chained, the host sends N words back to back, starting with the word for the driver furthest down the chain. It then raises load for one clock so that every driver takes its word at once.

The serial clock is the only clock. Load is sampled at that clock in the default hold style. The `HOLD_STYLE` parameter can select a level-sensitive latch instead.

Top module: `sdrv_core`

## Requirements
- R1: While rst_n is low at a rising clock edge, the shift register, the held word, all parallel outputs and ser_out become 0 after that edge, whatever the levels of ser_in, load and blank.
- R2: At each rising edge out of reset, the shift register moves every bit one place toward the most significant end, and ser_in enters bit 0. A bit driven on ser_in before edge 1 is therefore at bit 11 after edge 12.
- R3: ser_out always shows the most significant shift register bit. It changes only at a rising edge and equals the bit that was at position 10 before that edge.
- R4: At a rising edge with load high, the held word takes the shift register value from just before that edge. While load stays high, the held word follows the register one clock behind it.
- R5: At a rising edge with load low, the held word is unchanged, however many bits are shifted.
- R6: While blank is high, every parallel output is 0. The held word is not disturbed: when blank falls, the outputs show the same word as before, with no reload.
- R7: While blank is low, parallel output i equals bit i of the held word.
- R8: When ser_out of one driver feeds ser_in of the next, the chain acts as one shift register of (drivers × 12) bits. Driver k, counted from the data source, holds bits 12k+11 down to 12k of the combined value.
- R9: Word order is most significant bit first. The first bit sent for a word lands on parallel output 11 (D11), and the last bit sent lands on output 0 (D0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock. All state changes on its rising edge. |
| rst_n | input | 1 | Synchronous reset, active low. |
| ser_in | input | 1 | Serial data in, sampled at the rising edge. |
| load | input | 1 | Hold control. High copies the shift register to the held word. |
| blank | input | 1 | High forces all parallel outputs low. |
| drv_out | output | WIDTH (12) | Parallel channel outputs. |
| ser_out | output | 1 | Serial data out, for the next driver in a chain. |

## Verification
Shift, serial-out and hold results all come from registers, so each one is due at the first rising edge after its stimulus. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the edge that produced the result. A single marker bit is timed through one driver, and ser_out is checked one edge before, at, and one edge after the twelfth edge. During a held load the copy is checked edge by edge, one clock behind the register. Blank is combinational, but the bench still samples it on a falling edge. The chained checks compute the expected slices from a single 36-bit shifted value.

// File: rtl/sdrv_pkg.sv
// sdrv_pkg: types shared by the serial driver core and its checker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sdrv_pkg;

    // How the held word responds to the load input.
    typedef enum logic {
        HOLD_CLOCKED = 1'b0,   // load sampled at the serial clock edge
        HOLD_LEVEL   = 1'b1    // load acts as a transparent latch enable
    } hold_style_e;

endpackage

// File: rtl/sdrv_shift.sv
// sdrv_shift: serial-in shift register with serial-out at the top bit.
// Shifts toward the MSB every rising edge; the MSB leaves on ser_out.
// Assumes WIDTH >= 2 and a synchronous active-low reset.
module sdrv_shift #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] shift_q,
    output logic             ser_out
);

    localparam int TOP = WIDTH - 1;

    // Shift one place per clock, new bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[TOP-1:0], ser_in};
        end
    end

    // The overflow bit feeds the next driver in a chain.
    assign ser_out = shift_q[TOP];

endmodule

// File: rtl/sdrv_hold.sv
// sdrv_hold: holds the word shown on the parallel outputs.
// HOLD_CLOCKED copies the pre-edge shift value at each edge with load high.
// HOLD_LEVEL is a transparent latch that clears from a registered reset.
// Assumes shift_q comes from flops clocked by clk.
module sdrv_hold #(
    parameter int                  WIDTH      = 12,
    parameter sdrv_pkg::hold_style_e HOLD_STYLE = sdrv_pkg::HOLD_CLOCKED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] shift_q,
    output logic [WIDTH-1:0] hold_q
);

    if (HOLD_STYLE == sdrv_pkg::HOLD_LEVEL) begin : g_level
        logic clr_q;

        // Register the reset so that the latch clears in step with the flops.
        always_ff @(posedge clk) begin
            clr_q <= !rst_n;
        end

        // Transparent while load is high, opaque while it is low.
        always_latch begin
            if (clr_q) begin
                hold_q = '0;
            end else if (load) begin
                hold_q = shift_q;
            end
        end
    end else begin : g_clocked
        // Copy the shift register on every edge that sees load high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (load) begin
                hold_q <= shift_q;
            end
        end
    end

endmodule

// File: rtl/sdrv_gate.sv
// sdrv_gate: per-channel blanking of the held word.
// Purely combinational; blank forces every channel low.
module sdrv_gate #(
    parameter int WIDTH = 12
) (
    input  logic             blank,
    input  logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] drv_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_chan
        // Each channel passes its held bit unless blanked.
        assign drv_out[i] = hold_q[i] & ~blank;
    end

endmodule

// File: rtl/sdrv_core.sv
// sdrv_core: top of the cascadable serial-to-parallel driver core.
// Chains shift stage -> hold stage -> blank gate; ser_out serves cascading.
// Assumes one clock domain (the serial clock) and synchronous reset.
module sdrv_core #(
    parameter int                    WIDTH      = 12,
    parameter sdrv_pkg::hold_style_e HOLD_STYLE = sdrv_pkg::HOLD_CLOCKED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             load,
    input  logic             blank,
    output logic [WIDTH-1:0] drv_out,
    output logic             ser_out
);

    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] hold_q;

    sdrv_shift #(
        .WIDTH (WIDTH)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .shift_q (shift_q),
        .ser_out (ser_out)
    );

    sdrv_hold #(
        .WIDTH      (WIDTH),
        .HOLD_STYLE (HOLD_STYLE)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift_q (shift_q),
        .hold_q  (hold_q)
    );

    sdrv_gate #(
        .WIDTH (WIDTH)
    ) u_gate (
        .blank   (blank),
        .hold_q  (hold_q),
        .drv_out (drv_out)
    );

endmodule

// File: rtl/sdrv_core_chk.sv
// sdrv_core_chk: assertion checker bound to sdrv_core.
// Watches the shift, hold and gate stages through the core's nets.
module sdrv_core_chk #(
    parameter int                    WIDTH      = 12,
    parameter sdrv_pkg::hold_style_e HOLD_STYLE = sdrv_pkg::HOLD_CLOCKED
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_in,
    input logic             load,
    input logic             blank,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] hold_q,
    input logic [WIDTH-1:0] drv_out,
    input logic             ser_out
);

    localparam int TOP = WIDTH - 1;

    logic rst_seen_q;

    // Remember whether the last edge was taken in reset.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // Half a period after a reset edge, everything must read zero.
    always @(negedge clk) begin
        if (rst_seen_q === 1'b1) begin
            AST_RESET_CLEAR: assert (shift_q == '0 && hold_q == '0 && drv_out == '0 && ser_out == 1'b0); // R1
        end
    end

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> shift_q[0] == $past(ser_in)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> shift_q[TOP:1] == $past(shift_q[TOP-1:0])); // R2
    AST_SEROUT_TAIL: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> ser_out == $past(shift_q[TOP-1])); // R3
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n) blank |-> drv_out == '0); // R6
    AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) !blank |-> drv_out == hold_q); // R7

    if (HOLD_STYLE == sdrv_pkg::HOLD_CLOCKED) begin : g_clocked_props
        AST_HOLD_COPY: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(load)) |-> hold_q == $past(shift_q)); // R4
        AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && !$past(load)) |-> $stable(hold_q)); // R5
    end

endmodule

bind sdrv_core sdrv_core_chk #(
    .WIDTH      (WIDTH),
    .HOLD_STYLE (HOLD_STYLE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .load    (load),
    .blank   (blank),
    .shift_q (shift_q),
    .hold_q  (hold_q),
    .drv_out (drv_out),
    .ser_out (ser_out)
);

// File: tb/sdrv_core_bench.sv
// sdrv_core_bench: three chained drivers loaded from one serial line.
// Inputs change on the falling edge; results are sampled one falling edge later.
module sdrv_core_bench;

    localparam int WIDTH = 12;
    localparam int NDEV  = 3;
    localparam int CH    = WIDTH * NDEV;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic din   = 1'b0;
    logic load  = 1'b0;
    logic blank = 1'b0;

    wire [NDEV:0]   chain;
    wire [CH-1:0]   par_all;
    assign chain[0] = din;

    always #4 clk = ~clk;

    for (genvar k = 0; k < NDEV; k++) begin : g_chain
        sdrv_core #(.WIDTH(WIDTH)) u_sdrv_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .ser_in  (chain[k]),
            .load    (load),
            .blank   (blank),
            .drv_out (par_all[k*WIDTH +: WIDTH]),
            .ser_out (chain[k+1])
        );
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [CH-1:0] w);
        for (int i = CH - 1; i >= 0; i--) begin
            din = w[i];
            tick;
        end
        din = 1'b0;
    endtask

    task automatic pulse_load;
        load = 1'b1;
        tick;
        load = 1'b0;
    endtask

    // Expected ser_out of every driver once a full combined word sits in the chain.
    function automatic logic [CH-1:0] tails(input logic [CH-1:0] w);
        logic [CH-1:0] r = '0;
        for (int k = 0; k < NDEV; k++) r[k] = w[k*WIDTH + WIDTH - 1];
        return r;
    endfunction

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        logic [CH-1:0] prev;
        logic [CH-1:0] w;

        // R1: reset with every input pushing toward a nonzero state
        rst_n = 1'b0; din = 1'b1; load = 1'b1; blank = 1'b0;
        repeat (3) tick;
        chk("R1 outputs", par_all, '0);
        chk("R1 ser_out", CH'(chain[NDEV:1]), '0);
        rst_n = 1'b1; load = 1'b0; din = 1'b0;

        // R2/R3: one marker bit reaches ser_out of driver 0 exactly at edge 12
        din = 1'b1;
        tick;
        din = 1'b0;
        for (int j = 2; j <= 13; j++) begin
            tick;
            if (j >= 11) chk("R2/R3 marker timing", CH'(chain[1]), CH'(j == 12));
        end

        // Several words: load low keeps the old word, load copies the new one
        prev = '0;
        for (int p = 0; p < 6; p++) begin
            if (p == 0)      w = '1;
            else if (p == 1) w = '0;
            else             w = CH'(64'h9E37_79B9_7F4A_7C15 * (p + 3));
            send_word(w);
            chk("R5 held during shift", par_all, prev);
            chk("R3/R8 chain tails", CH'(chain[NDEV:1]), tails(w));
            pulse_load;
            chk("R4/R7/R8 loaded word", par_all, w);
            prev = w;
        end

        // R6: blank darkens outputs, shifting under blank, then the same word returns
        blank = 1'b1;
        tick;
        chk("R6 blank dark", par_all, '0);
        for (int i = 0; i < 5; i++) begin
            din = i[0];
            tick;
        end
        din = 1'b0;
        chk("R6 still dark", par_all, '0);
        blank = 1'b0;
        tick;
        chk("R6 word survives blank", par_all, prev);

        // R4: load held high, the copy trails the register by one clock
        w = CH'(36'hC_3A5F_0E91);
        send_word(w);
        load = 1'b1;
        for (int j = 1; j <= 3; j++) begin
            tick;
            chk("R4 load held lag", par_all, w << (j - 1));
        end
        load = 1'b0;
        prev = w << 2;
        send_word(CH'(36'h5_5555_5555));
        chk("R5 hold after long load", par_all, prev);

        // R9/R8: walking single one across every position of the chain
        for (int pos = 0; pos < CH; pos++) begin
            w = CH'(1) << pos;
            send_word(w);
            pulse_load;
            chk("R9/R8 walking bit", par_all, w);
        end

        // R1: reset in the middle of operation
        din = 1'b1; load = 1'b1; blank = 1'b0;
        rst_n = 1'b0;
        tick;
        chk("R1 mid-run outputs", par_all, '0);
        chk("R1 mid-run ser_out", CH'(chain[NDEV:1]), '0);
        rst_n = 1'b1; load = 1'b0; din = 1'b0;
        tick;

        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run;
        end
    end

endmodule